// File: doc/BRIEF.md
# Peripheral Domain Power-Down Sequencer

This controller takes one clock domain that sits behind a register-crossing path safely to an off state and back, without ever removing power. It owns three control outputs for the domain: a bypass flag that makes the bus side answer requests as no-ops, the domain's reset, and the domain's clock enable. An idle input reports that no bus transfer is still in flight across the crossing. Two request inputs ask for a power-down or a power-up. Two status outputs say when the domain is fully off and when it is fully on.

In the default mode the sequenced domain is the responding side of the crossing. Going down, the bypass flag rises first. The block then waits for idle, asserts reset, and optionally stops the clock. Coming back, it re-enables the clock, holds reset for a settling window so the crossing synchronizers can flush, releases reset, and only then clears bypass. A parameter selects the requesting-side mode instead. That mode uses the same drain, reset and clock ordering, but it never raises bypass. Another parameter decides whether the clock is gated in the off state.

A built-in order monitor raises a sticky error flag if reset is asserted on a responding-side domain that was running while bypass was low. All outputs come from registers. Leaving reset, the controller is in the fully-on state.

Top module: `dom_pwr_seq`

## Requirements
- R1: While rst_n is low and after it is released, the outputs are bypass_o=0, dom_rst_o=0, clk_en_o=1, dom_on_o=1, dom_off_o=0 and order_err_o=0.
- R2: In the fully-on state, off_req high at a clock edge raises bypass_o at that edge (responding-side mode), while dom_rst_o stays 0 and clk_en_o stays 1.
- R3: While draining, dom_rst_o rises only at the first edge where idle is sampled high, never at the edge that raised bypass, and bypass_o is already high on the cycle before.
- R4: With GATE_CLK=1, clk_en_o falls exactly one edge after dom_rst_o rises, and clk_en_o is never low while dom_rst_o is low. With GATE_CLK=0, clk_en_o stays 1 at all times.
- R5: In the off state, on_req high at an edge sets clk_en_o=1 at that edge and keeps dom_rst_o=1 for SETTLE_CYC cycles. dom_rst_o falls at the next edge, and bypass_o falls one edge after that, giving the fully-on state.
- R6: With MASTER_MODE=1, bypass_o is never high. The drain, reset, clock and settling steps keep the same order and timing as in R2 to R5.
- R7: on_req has no effect outside the off state, and off_req has no effect outside the fully-on state. If both are high in either stable state, only the request that applies to that state acts.
- R8: dom_off_o is 1 exactly in the off state (reset held, clock gated if enabled). dom_on_o is 1 exactly in the fully-on state, and the two are never 1 together.
- R9: In responding-side mode, order_err_o becomes 1 and stays 1 if dom_rst_o rises while bypass_o was 0 the cycle before. It stays 0 through every sequence this controller produces.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock (free running) |
| rst_n | input | 1 | Active-low asynchronous reset of the controller |
| off_req | input | 1 | Request to take the domain down |
| on_req | input | 1 | Request to bring the domain up |
| idle | input | 1 | High when no transfer is in flight across the crossing |
| bypass_o | output | 1 | Make bus requests to the domain complete as no-ops |
| dom_rst_o | output | 1 | Reset to the sequenced domain, active high |
| clk_en_o | output | 1 | Clock enable for the sequenced domain |
| dom_off_o | output | 1 | Domain is fully off |
| dom_on_o | output | 1 | Domain is fully on |
| order_err_o | output | 1 | Sticky flag: reset asserted on a live domain without bypass |

## Verification
Two functions can fall in the same cycle: a request and the drain-complete signal. The bench provokes this by raising off_req with idle already high. It also holds on_req and off_req high together in each stable state, and keeps the opposite request high through the drain and the settling window. Each such cycle is judged by the outputs at the following falling edge. Reset must still trail bypass by one edge, the request that does not apply must leave no trace, and the settling count must not restart. A sweep over drain lengths from zero to three cycles runs on a responding-side instance with clock gating and on a requesting-side instance without gating at the same time.

// File: rtl/dps_pkg.sv
package dps_pkg;

  typedef enum logic [2:0] {
    ST_ON    = 3'd0,
    ST_DRAIN = 3'd1,
    ST_RST   = 3'd2,
    ST_OFF   = 3'd3,
    ST_WAKE  = 3'd4,
    ST_REL   = 3'd5
  } seq_state_e;

  typedef struct packed {
    logic byp;
    logic rst;
    logic ce;
  } dom_drv_t;

  // Control levels that belong to each state; mode bits pick the variant.
  function automatic dom_drv_t drv_of(seq_state_e st, logic master, logic gate);
    dom_drv_t d;
    d.byp = (st != ST_ON) && !master;
    d.rst = (st == ST_RST) || (st == ST_OFF) || (st == ST_WAKE);
    d.ce  = !((st == ST_OFF) && gate);
    return d;
  endfunction

  function automatic logic settle_done(int unsigned cnt, int unsigned settle);
    return cnt == settle - 1;
  endfunction

endpackage

// File: rtl/dps_settle_cnt.sv
module dps_settle_cnt #(
  parameter int unsigned SETTLE_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int unsigned CW = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (run) cnt_q <= cnt_q + 1'b1;
    else          cnt_q <= '0;
  end

  assign done = run && dps_pkg::settle_done(int'(cnt_q), SETTLE_CYC);
endmodule

// File: rtl/dps_order_mon.sv
module dps_order_mon #(
  parameter bit MASTER_MODE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_next,
  input  logic rst_now,
  input  logic byp_now,
  output logic err
);
  logic bad_edge;

  generate
    if (MASTER_MODE) begin : g_off
      assign bad_edge = 1'b0;
    end else begin : g_on
      assign bad_edge = rst_next && !rst_now && !byp_now;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err <= 1'b0;
    else        err <= err | bad_edge;
  end
endmodule

// File: rtl/dps_fsm.sv
module dps_fsm
  import dps_pkg::*;
#(
  parameter bit MASTER_MODE = 1'b0,
  parameter bit GATE_CLK    = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       off_req,
  input  logic       on_req,
  input  logic       idle,
  input  logic       settle_done,
  output logic       in_wake,
  output dom_drv_t   drv_next,
  output dom_drv_t   drv_q,
  output logic       is_on_q,
  output logic       is_off_q
);
  seq_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_ON:    if (off_req)     st_d = ST_DRAIN;
      ST_DRAIN: if (idle)        st_d = ST_RST;
      ST_RST:                    st_d = ST_OFF;
      ST_OFF:   if (on_req)      st_d = ST_WAKE;
      ST_WAKE:  if (settle_done) st_d = ST_REL;
      ST_REL:                    st_d = ST_ON;
      default:                   st_d = ST_ON;
    endcase
  end

  assign in_wake  = (st_q == ST_WAKE);
  assign drv_next = drv_of(st_d, MASTER_MODE, GATE_CLK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_ON;
      drv_q    <= drv_of(ST_ON, MASTER_MODE, GATE_CLK);
      is_on_q  <= 1'b1;
      is_off_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      drv_q    <= drv_next;
      is_on_q  <= (st_d == ST_ON);
      is_off_q <= (st_d == ST_OFF);
    end
  end
endmodule

// File: rtl/dom_pwr_seq.sv
module dom_pwr_seq #(
  parameter bit          MASTER_MODE = 1'b0,
  parameter bit          GATE_CLK    = 1'b1,
  parameter int unsigned SETTLE_CYC  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic off_req,
  input  logic on_req,
  input  logic idle,
  output logic bypass_o,
  output logic dom_rst_o,
  output logic clk_en_o,
  output logic dom_off_o,
  output logic dom_on_o,
  output logic order_err_o
);
  import dps_pkg::*;

  // Named internal events, visible to the bound checker.
  logic     wake_run;
  logic     wake_done;
  dom_drv_t drv_next;
  dom_drv_t drv_q;

  dps_settle_cnt #(.SETTLE_CYC(SETTLE_CYC)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (wake_run),
    .done  (wake_done)
  );

  dps_fsm #(.MASTER_MODE(MASTER_MODE), .GATE_CLK(GATE_CLK)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .off_req     (off_req),
    .on_req      (on_req),
    .idle        (idle),
    .settle_done (wake_done),
    .in_wake     (wake_run),
    .drv_next    (drv_next),
    .drv_q       (drv_q),
    .is_on_q     (dom_on_o),
    .is_off_q    (dom_off_o)
  );

  dps_order_mon #(.MASTER_MODE(MASTER_MODE)) u_mon (
    .clk      (clk),
    .rst_n    (rst_n),
    .rst_next (drv_next.rst),
    .rst_now  (drv_q.rst),
    .byp_now  (drv_q.byp),
    .err      (order_err_o)
  );

  assign bypass_o  = drv_q.byp;
  assign dom_rst_o = drv_q.rst;
  assign clk_en_o  = drv_q.ce;
endmodule

// File: rtl/dps_chk.sv
module dps_chk #(
  parameter bit MASTER_MODE = 1'b0,
  parameter bit GATE_CLK    = 1'b1
) (
  input logic clk,
  input logic rst_n,
  input logic idle,
  input logic wake_run,
  input logic bypass_o,
  input logic dom_rst_o,
  input logic clk_en_o,
  input logic dom_off_o,
  input logic dom_on_o,
  input logic order_err_o
);
  p_byp_before_rst_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!MASTER_MODE && $rose(dom_rst_o)) |-> $past(bypass_o));

  p_drain_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dom_rst_o) |-> $past(idle));

  p_gate_in_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en_o |-> dom_rst_o);

  p_gate_after_rst_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_en_o) |-> $past(dom_rst_o));

  p_no_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !GATE_CLK |-> clk_en_o);

  p_clk_before_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dom_rst_o) |-> ($past(clk_en_o) && $past(wake_run)));

  p_byp_after_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bypass_o) |-> (!dom_rst_o && !$past(dom_rst_o)));

  p_master_no_byp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    MASTER_MODE |-> !bypass_o);

  p_status_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(dom_on_o && dom_off_o));

  p_on_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dom_on_o |-> (!bypass_o && !dom_rst_o && clk_en_o));

  p_no_order_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !order_err_o);
endmodule

bind dom_pwr_seq dps_chk #(.MASTER_MODE(MASTER_MODE), .GATE_CLK(GATE_CLK)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .idle        (idle),
  .wake_run    (wake_run),
  .bypass_o    (bypass_o),
  .dom_rst_o   (dom_rst_o),
  .clk_en_o    (clk_en_o),
  .dom_off_o   (dom_off_o),
  .dom_on_o    (dom_on_o),
  .order_err_o (order_err_o)
);

// File: tb/tb_dom_pwr_seq.sv
module tb_dom_pwr_seq;
  localparam int CLK_PER = 10;
  localparam int SETTLE  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic off_req = 1'b0, on_req = 1'b0, idle = 1'b0;
  logic s_byp, s_rst, s_ce, s_off, s_on, s_err;
  logic m_byp, m_rst, m_ce, m_off, m_on, m_err;
  int   n_chk = 0, n_err = 0;
  bit   finished = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  dom_pwr_seq #(.MASTER_MODE(1'b0), .GATE_CLK(1'b1), .SETTLE_CYC(SETTLE)) dut (
    .clk(clk), .rst_n(rst_n), .off_req(off_req), .on_req(on_req), .idle(idle),
    .bypass_o(s_byp), .dom_rst_o(s_rst), .clk_en_o(s_ce),
    .dom_off_o(s_off), .dom_on_o(s_on), .order_err_o(s_err));

  dom_pwr_seq #(.MASTER_MODE(1'b1), .GATE_CLK(1'b0), .SETTLE_CYC(SETTLE)) dut_m (
    .clk(clk), .rst_n(rst_n), .off_req(off_req), .on_req(on_req), .idle(idle),
    .bypass_o(m_byp), .dom_rst_o(m_rst), .clk_en_o(m_ce),
    .dom_off_o(m_off), .dom_on_o(m_on), .order_err_o(m_err));

  // Bench phases: 0 on, 1 draining, 2 reset, 3 off, 4 waking, 5 releasing.
  // Expected {bypass, reset, clk_en, on, off, err}.
  function automatic logic [5:0] expect_of(int ph, bit master, bit gate);
    logic b, r, c;
    b = (ph != 0) && !master;
    r = (ph >= 2) && (ph <= 4);
    c = !(ph == 3 && gate);
    return {b, r, c, ph == 0, ph == 3, 1'b0};
  endfunction

  task automatic check(string req, int ph);
    logic [5:0] gs, gm, es, em;
    gs = {s_byp, s_rst, s_ce, s_on, s_off, s_err};
    gm = {m_byp, m_rst, m_ce, m_on, m_off, m_err};
    es = expect_of(ph, 1'b0, 1'b1);
    em = expect_of(ph, 1'b1, 1'b0);
    n_chk++;
    if (gs !== es) begin
      n_err++;
      $display("FAIL %s slave-mode phase %0d: got %b expected %b", req, ph, gs, es);
    end
    n_chk++;
    if (gm !== em) begin
      n_err++;
      $display("FAIL R6 (%s) master-mode phase %0d: got %b expected %b", req, ph, gm, em);
    end
  endtask

  // Inputs change at a falling edge; results are read at the next falling edge.
  task automatic step(logic o, logic n, logic i);
    off_req = o; on_req = n; idle = i;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PER * 20000);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", 0);
    rst_n = 1'b1;
    step(0, 0, 1); check("R1 after reset", 0);
    step(0, 1, 1); check("R7 on_req while on", 0);
    step(0, 1, 0); check("R7 on_req while on", 0);

    for (int dw = 0; dw < 4; dw++) begin
      // off_req together with on_req; idle already high when dw==0.
      step(1, 1, dw == 0); check("R2 bypass first", 1);
      for (int k = 0; k < dw; k++) begin
        step(0, 1, 0); check("R3 hold while busy", 1);
      end
      step(0, 0, 1); check("R3 reset after idle", 2);
      step(0, 0, 1); check("R4 clock gated after reset", 3);
      step(1, 0, dw[0]); check("R7 off_req while off", 3);
      step(0, 0, 0); check("R8 still off", 3);
      step(1, 1, 1); check("R5 clock back, reset held", 4);
      for (int k = 0; k < SETTLE - 1; k++) begin
        step(1, 0, k[0]); check("R5 settling, R7 off_req ignored", 4);
      end
      step(0, 0, 1); check("R5 reset released", 5);
      step(0, 0, 1); check("R5 bypass cleared, R8 on", 0);
      step(0, 0, 0); check("R9 no order error", 0);
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule